// File: doc/BRIEF.md
# I2C SCL Clock Generator with Standard and Fast Modes

This block produces the serial clock for an I2C master from the system clock. A 9-bit divider value and a one-bit speed select decide the SCL period. In standard speed the low and high halves have equal length. In fast speed the same divider value gives a low half twice as long as the high half. Software loads the configuration through two write ports. A byte-wide control port carries the speed bit and the lower seven divider bits. A narrow extension port carries the two upper divider bits.

The enable input starts and stops the clock. While the block is stopped, SCL rests high. When the block starts, it begins with a low half. The block also gives a one-cycle strobe on each SCL edge, so a neighbouring data shifter can drive SDA after a falling edge and sample it after a rising edge. Configuration written while a period is running is held back until the next period begins. This keeps every half of the SCL waveform whole.

There is no data stream through this block. All pins are plain control or status pins, so no valid/ready handshake and no back-pressure apply.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, SCL is high, both strobes are low, and the configuration is zero. Enabling with no writes gives standard speed with divider 0: 2 cycles low, then 2 cycles high.
- R2: A write on the control port loads the speed bit from bit 7 (0 = standard, 1 = fast) and divider bits 6:0 from bits 6:0. Divider bits 8:7 are left unchanged.
- R3: A write on the extension port loads divider bits 8:7 from its bits 1:0. The speed bit and divider bits 6:0 are left unchanged.
- R4: In standard speed with divider D, SCL is low for D+2 cycles and then high for D+2 cycles.
- R5: In fast speed with divider D, SCL is low for 2·(D+2) cycles and then high for D+2 cycles.
- R6: While enable is low, SCL is high from the next cycle on, no strobe fires, and the period count is held at zero.
- R7: In the first cycle after enable is sampled high, SCL goes low and the falling strobe fires, so every run begins with a full low half.
- R8: Dropping enable does not clear the speed bit or the divider. Enabling again reproduces the same period.
- R9: A configuration write during a running period does not change that period. It applies from the next falling edge, when the next period starts.
- R10: The rising and falling strobes last one cycle each, appear in the first cycle of the new SCL level, and never fire together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; SCL rests high while low |
| ctl_we | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Bit 7 speed select, bits 6:0 divider bits 6:0 |
| ext_we | input | 1 | Write strobe for the extension field |
| ext_wdata | input | 2 | Divider bits 8:7 |
| scl_o | output | 1 | Registered SCL level |
| scl_rise_o | output | 1 | High in the first cycle SCL is high |
| scl_fall_o | output | 1 | High in the first cycle SCL is low |

## Verification
A write to either port reaches the configuration registers one clock later. The bench therefore changes the configuration only while the block is stopped, or deliberately in the middle of a period, and then counts whole periods. Raising enable gives SCL low and the falling strobe one clock later, so the bench samples at the next falling clock edge. From there it counts falling edges with SCL low and then with SCL high, and compares each count with the lengths computed from the divider and the speed bit. For a mid-period write, the period in progress must keep its old lengths and the period after it must show the new ones. Over a window of idle cycles, SCL must stay high with both strobes quiet.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic {
    SPD_STD  = 1'b0,
    SPD_FAST = 1'b1
  } scl_speed_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_pkg::*;
#(
  parameter int DIV_W = 9,
  parameter int LO_W  = 7,
  localparam int HI_W = DIV_W - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [LO_W:0]    ctl_wdata,
  input  logic             ext_we,
  input  logic [HI_W-1:0]  ext_wdata,
  output scl_speed_e       cfg_speed,
  output logic [DIV_W-1:0] cfg_div
);

  logic [LO_W-1:0] div_lo_q;
  logic [HI_W-1:0] div_hi_q;
  scl_speed_e      speed_q;

  // Control byte: the top bit is the speed select, the rest are the low divider bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q  <= SPD_STD;
      div_lo_q <= '0;
    end else if (ctl_we) begin
      speed_q  <= scl_speed_e'(ctl_wdata[LO_W]);
      div_lo_q <= ctl_wdata[LO_W-1:0];
    end
  end

  // Extension field: the upper divider bits only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_hi_q <= '0;
    end else if (ext_we) begin
      div_hi_q <= ext_wdata;
    end
  end

  assign cfg_speed = speed_q;
  assign cfg_div   = {div_hi_q, div_lo_q};

endmodule

// File: rtl/scl_period_calc.sv
module scl_period_calc
  import scl_pkg::*;
#(
  parameter int DIV_W = 9,
  parameter int CNT_W = DIV_W + 2
) (
  input  scl_speed_e       speed,
  input  logic [DIV_W-1:0] div,
  output logic [CNT_W-1:0] low_last,
  output logic [CNT_W-1:0] per_last
);

  logic [CNT_W-1:0] unit_len;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] per_len;

  // The unit is div + 2. Fast speed doubles the low half using only a shift.
  always_comb begin
    unit_len = CNT_W'(div) + CNT_W'(2);
    low_len  = (speed == SPD_FAST) ? (unit_len << 1) : unit_len;
    per_len  = low_len + unit_len;
    low_last = low_len - CNT_W'(1);
    per_last = per_len - CNT_W'(1);
  end

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_pkg::*;
#(
  parameter int DIV_W = 9,
  parameter int CNT_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  scl_speed_e       cfg_speed,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [CNT_W-1:0] low_last,
  input  logic [CNT_W-1:0] per_last,
  output scl_speed_e       shd_speed,
  output logic [DIV_W-1:0] shd_div,
  output logic [CNT_W-1:0] cnt_o,
  output logic             scl_o,
  output logic             rise_o,
  output logic             fall_o
);

  scl_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  scl_speed_e       shd_speed_q;
  logic [DIV_W-1:0] shd_div_q;
  logic             rise_q;
  logic             fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      shd_speed_q <= SPD_STD;
      shd_div_q   <= '0;
      rise_q      <= 1'b0;
      fall_q      <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!en) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (phase_q)
          PH_IDLE: begin
            // The first period starts with the low half, using the current configuration
            phase_q     <= PH_LOW;
            cnt_q       <= '0;
            shd_speed_q <= cfg_speed;
            shd_div_q   <= cfg_div;
            fall_q      <= 1'b1;
          end
          PH_LOW: begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == low_last) begin
              phase_q <= PH_HIGH;
              rise_q  <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (cnt_q == per_last) begin
              // Period boundary: the only point where new configuration is taken up
              phase_q     <= PH_LOW;
              cnt_q       <= '0;
              shd_speed_q <= cfg_speed;
              shd_div_q   <= cfg_div;
              fall_q      <= 1'b1;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end
        endcase
      end
    end
  end

  assign shd_speed = shd_speed_q;
  assign shd_div   = shd_div_q;
  assign cnt_o     = cnt_q;
  assign scl_o     = (phase_q != PH_LOW);
  assign rise_o    = rise_q;
  assign fall_o    = fall_q;

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_pkg::*;
#(
  parameter int DIV_W = 9,
  parameter int LO_W  = 7,
  localparam int HI_W  = DIV_W - LO_W,
  localparam int CNT_W = DIV_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            ctl_we,
  input  logic [LO_W:0]   ctl_wdata,
  input  logic            ext_we,
  input  logic [HI_W-1:0] ext_wdata,
  output logic            scl_o,
  output logic            scl_rise_o,
  output logic            scl_fall_o
);

  scl_speed_e       cfg_speed;
  logic [DIV_W-1:0] cfg_div;
  scl_speed_e       shd_speed;
  logic [DIV_W-1:0] shd_div;
  logic [CNT_W-1:0] low_last;
  logic [CNT_W-1:0] per_last;
  logic [CNT_W-1:0] cnt;

  scl_cfg_regs #(.DIV_W(DIV_W), .LO_W(LO_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ext_we    (ext_we),
    .ext_wdata (ext_wdata),
    .cfg_speed (cfg_speed),
    .cfg_div   (cfg_div)
  );

  scl_period_calc #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_calc (
    .speed    (shd_speed),
    .div      (shd_div),
    .low_last (low_last),
    .per_last (per_last)
  );

  scl_phase_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cfg_speed (cfg_speed),
    .cfg_div   (cfg_div),
    .low_last  (low_last),
    .per_last  (per_last),
    .shd_speed (shd_speed),
    .shd_div   (shd_div),
    .cnt_o     (cnt),
    .scl_o     (scl_o),
    .rise_o    (scl_rise_o),
    .fall_o    (scl_fall_o)
  );

endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk
  import scl_pkg::*;
#(
  parameter int DIV_W = 9,
  parameter int CNT_W = DIV_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             ctl_we,
  input logic             ext_we,
  input logic             scl_o,
  input logic             scl_rise_o,
  input logic             scl_fall_o,
  input scl_speed_e       cfg_speed,
  input logic [DIV_W-1:0] cfg_div,
  input scl_speed_e       shd_speed,
  input logic [DIV_W-1:0] shd_div,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_last
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !scl_rise_o && !scl_fall_o && cnt == '0)); // R6

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (scl_fall_o && !scl_o)); // R7

  AST_CFG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !ext_we) |=> ($stable(cfg_div) && $stable(cfg_speed))); // R8

  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall_o |-> ($stable(shd_div) && $stable(shd_speed))); // R9

  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_o |-> (scl_o && !$past(scl_o))); // R10

  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_o |-> (!scl_o && $past(scl_o))); // R10

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise_o && scl_fall_o)); // R10

  AST_RISE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_o) && $past(en)) |-> scl_rise_o); // R10

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_last); // R5

endmodule

bind scl_clkgen scl_clkgen_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .ctl_we     (ctl_we),
  .ext_we     (ext_we),
  .scl_o      (scl_o),
  .scl_rise_o (scl_rise_o),
  .scl_fall_o (scl_fall_o),
  .cfg_speed  (cfg_speed),
  .cfg_div    (cfg_div),
  .shd_speed  (shd_speed),
  .shd_div    (shd_div),
  .cnt        (cnt),
  .per_last   (per_last)
);

// File: tb/test_scl_clkgen.sv
`timescale 1ns/1ps
module test_scl_clkgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       ext_we = 1'b0;
  logic [1:0] ext_wdata = '0;
  logic       scl_o;
  logic       scl_rise_o;
  logic       scl_fall_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  scl_clkgen i_scl_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .ext_we     (ext_we),
    .ext_wdata  (ext_wdata),
    .scl_o      (scl_o),
    .scl_rise_o (scl_rise_o),
    .scl_fall_o (scl_fall_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic write_ext(input logic [1:0] v);
    ext_we = 1'b1; ext_wdata = v;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  // Called at the negedge where the falling strobe is expected. Returns at the
  // negedge where the next falling strobe is expected. Optionally writes the
  // control byte during the low half, at low-cycle index wr_at.
  task automatic run_period(input int exp_lo, input int exp_hi, input string req,
                            input int wr_at, input logic [7:0] wr_val);
    int lo = 0;
    int hi = 0;
    chk(scl_fall_o === 1'b1 && scl_o === 1'b0, {req, " R10 fall strobe at low start"},
        int'(scl_fall_o), 1);
    while (scl_o === 1'b0 && lo < 5000) begin
      ctl_we    = (lo == wr_at);
      ctl_wdata = wr_val;
      lo++;
      @(negedge clk);
    end
    ctl_we = 1'b0;
    chk(scl_rise_o === 1'b1, {req, " R10 rise strobe at high start"}, int'(scl_rise_o), 1);
    chk(lo == exp_lo, {req, " low length"}, lo, exp_lo);
    while (scl_o === 1'b1 && hi < 5000) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == exp_hi, {req, " high length"}, hi, exp_hi);
  endtask

  task automatic start_run();
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_run();
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic config_all(input bit fast, input int d);
    logic [8:0] dv;
    dv = 9'(d);
    write_ctl({fast, dv[6:0]});
    write_ext(dv[8:7]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int sweep [16] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 63, 127, 128, 300, 400, 511};

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(scl_o === 1'b1 && scl_rise_o === 1'b0 && scl_fall_o === 1'b0,
        "R1 reset outputs", int'({scl_o, scl_rise_o, scl_fall_o}), 4);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 zero configuration after reset; R7 the first period starts with the low half
    start_run();
    run_period(2, 2, "R1 R7 reset config", -1, 8'h00);
    run_period(2, 2, "R1 R4 second period", -1, 8'h00);
    stop_run();

    // R4 / R5 sweep over both speeds; R2 and R3 place the fields
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 16; i++) begin
        int d;
        int u;
        d = sweep[i];
        u = d + 2;
        config_all(m[0], d);
        start_run();
        if (m == 0) run_period(u, u, "R2 R3 R4 std sweep", -1, 8'h00);
        else        run_period(2 * u, u, "R2 R3 R5 fast sweep", -1, 8'h00);
        if (m == 0) run_period(u, u, "R4 std repeat", -1, 8'h00);
        else        run_period(2 * u, u, "R5 fast repeat", -1, 8'h00);
        stop_run();
      end
    end

    // R3: the extension write alone keeps speed and low bits (std, 5 | 1<<7 = 133)
    write_ctl(8'h05);
    write_ext(2'b00);
    write_ext(2'b01);
    start_run();
    run_period(135, 135, "R3 ext only", -1, 8'h00);
    stop_run();
    // R2: the control write alone keeps the upper bits (fast, 2 | 128 = 130)
    write_ctl(8'h82);
    start_run();
    run_period(264, 132, "R2 ctl keeps upper", -1, 8'h00);
    stop_run();
    write_ext(2'b00);

    // R6 idle: SCL high, no strobes, for a window of cycles mid-period
    config_all(1'b0, 6);
    start_run();
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    begin
      int bad = 0;
      for (int k = 0; k < 40; k++) begin
        if (scl_o !== 1'b1 || scl_rise_o !== 1'b0 || scl_fall_o !== 1'b0) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R6 idle released and quiet", bad, 0);
    end

    // R8 config survives disable; R6 count restarted from zero gives a full first period
    start_run();
    run_period(8, 8, "R8 R6 restart after disable", -1, 8'h00);
    stop_run();

    // R9 mid-period write: current period unchanged, next one uses new values
    config_all(1'b0, 4);
    start_run();
    run_period(6, 6, "R9 period during write", 2, 8'h0a);
    run_period(12, 12, "R9 next period std", -1, 8'h00);
    run_period(12, 12, "R9 mid-low switch to fast", 3, 8'h83);
    run_period(10, 5, "R9 R5 next period fast", -1, 8'h00);
    stop_run();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule